// File: doc/BRIEF.md
# Dual-Format MDIO Management Slave

This block is the serial management port of a PHY. It runs on the management clock, samples the bidirectional data line on every rising edge, and recognises two frame layouts that share one bus. Both layouts start with a run of ones and a start pair, followed by an opcode pair, a 5-bit port number, a 5-bit second field, a 2-bit turnaround and 16 data bits. A start pair of `01` selects the short layout, where the second field is a register number. A start pair of `00` selects the extended layout, where the second field names a device inside the port.

Frames whose port number differs from the strapped `port_id` are tracked to their end but have no effect. A frame for this port is handed to the register side as a one-cycle strobe. The strobe carries the layout flag, the opcode, the second field and, for writes, the data word. On read frames the strobe fires early. The block samples `rd_data` on the next edge, drives the second turnaround bit low and then shifts the word out MSB first. `mdio_oe` controls the external tri-state buffer.

Top module: `mdio_slave`

## Requirements
- R1: A frame is only accepted when at least 32 consecutive ones are sampled immediately before its first start bit (a 0). After 31 ones the frame yields no strobe and no drive. After every frame or abort, a fresh run of 32 ones is needed.
- R2: Start pair `01` (short layout): opcode `10` is a read and `01` is a write. The strobe shows `txn_ext`=0, the opcode as received, and the register number in `txn_addr`.
- R3: Start pair `00` (extended layout): all four opcodes are accepted: `00` address, `01` write, `11` read, `10` read with increment. Opcodes with bit 1 set are reads. The strobe shows `txn_ext`=1, the opcode and the device number in `txn_addr`.
- R4: In the short layout, opcodes `00` and `11` abort the frame back to preamble search, with no strobe and no drive. The next properly framed transaction is still decoded.
- R5: A frame whose port field differs from `port_id` produces no strobe, and `mdio_oe` stays low throughout it.
- R6: For write and address frames, `txn_valid` is high for exactly the cycle after the edge that samples the last data bit. `txn_wdata` then holds the 16 data bits, MSB received first.
- R7: For read frames, `txn_valid` is high for the cycle after the edge that samples the last bit of the second 5-bit field. `txn_wdata` is then 0. `rd_data` is captured on the following edge.
- R8: On a matching read, `mdio_oe` rises after the edge that samples the first turnaround bit and stays high for exactly 17 cycles. During that time `mdio_o` carries a 0 and then `rd_data` bits 15 down to 0.
- R9: `mdio_o` is 0 whenever `mdio_oe` is 0.
- R10: `txn_valid` is never high in two consecutive cycles, and fires at most once per frame.
- R11: During and directly after reset, `txn_valid`, `mdio_oe` and `mdio_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; line sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Sampled level of the management data line |
| port_id | input | 5 | Strapped port number of this PHY |
| rd_data | input | 16 | Read word from the register side, sampled one edge after a read strobe |
| mdio_o | output | 1 | Level driven onto the line while enabled |
| mdio_oe | output | 1 | Output enable for the line's tri-state buffer |
| txn_valid | output | 1 | One-cycle transaction strobe |
| txn_ext | output | 1 | 1 for the extended layout, 0 for the short layout |
| txn_op | output | 2 | Opcode pair as received |
| txn_addr | output | 5 | Register number (short) or device number (extended) |
| txn_wdata | output | 16 | Write or address data; 0 on read strobes |

## Verification
Several properties are checked on every cycle. The strobe is never two cycles long. A start is only taken after a full preamble, and no illegal short opcode gets past the opcode field. The output enable only rises right after a read strobe, always begins with a low turnaround bit and drops once the word has been shifted out. The line output stays quiet while disabled. Other properties need the bench's scenarios: how port matching is swept across all 32 addresses, field contents and strobe timing relative to bit positions, the serialised read word, the 31-versus-32 preamble boundary, and recovery after an aborted frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PORT_W  = 5;
    localparam int FIELD_W = 5;
    localparam int OP_W    = 2;
    localparam int DATA_W  = 16;

    typedef enum logic [2:0] {
        S_HUNT, S_ST2, S_OP, S_PORT, S_ADDR, S_TA, S_DATA
    } rx_state_e;

    typedef struct packed {
        logic                ext;
        logic [OP_W-1:0]     op;
        logic [FIELD_W-1:0]  addr;
        logic [DATA_W-1:0]   data;
    } mgmt_txn_t;

    function automatic logic op_is_read(input logic ext, input logic [OP_W-1:0] op);
        return ext ? op[1] : (op == 2'b10);
    endfunction

    function automatic logic op_is_legal(input logic ext, input logic [OP_W-1:0] op);
        return ext || (op == 2'b10) || (op == 2'b01);
    endfunction
endpackage

// File: rtl/mdio_preamble.sv
module mdio_preamble #(
    parameter int PRE_MIN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic hunt,
    input  logic bit_in,
    output logic pre_ok
);
    localparam int CW = $clog2(PRE_MIN + 1);
    logic [CW-1:0] ones;

    always_ff @(posedge clk) begin
        if (rst || !hunt || !bit_in)
            ones <= '0;
        else if (ones != CW'(PRE_MIN))
            ones <= ones + 1'b1;
    end

    assign pre_ok = (ones == CW'(PRE_MIN));

    assert_ones_bound_R1: assert property (@(posedge clk) disable iff (rst)
        ones <= CW'(PRE_MIN));
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              pre_ok,
    input  logic [PORT_W-1:0] port_id,
    output logic              hunt,
    output logic              txn_valid,
    output logic              rd_start,
    output mgmt_txn_t         txn
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] LAST_PORT = CNT_W'(PORT_W - 1);
    localparam logic [CNT_W-1:0] LAST_FLD  = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0] LAST_TA   = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_DAT  = CNT_W'(DATA_W - 1);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic                 ext;
    logic [OP_W-1:0]      op;
    logic [PORT_W-1:0]    port_sh;
    logic [FIELD_W-1:0]   addr_sh;
    logic [DATA_W-1:0]    data_sh;
    logic                 active;
    logic                 reading;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_HUNT;
            cnt       <= '0;
            ext       <= 1'b0;
            op        <= '0;
            port_sh   <= '0;
            addr_sh   <= '0;
            data_sh   <= '0;
            active    <= 1'b0;
            reading   <= 1'b0;
            txn_valid <= 1'b0;
            rd_start  <= 1'b0;
        end else begin
            txn_valid <= 1'b0;
            rd_start  <= 1'b0;
            case (state)
                S_HUNT: if (!bit_in && pre_ok) state <= S_ST2;
                S_ST2: begin
                    ext     <= !bit_in;
                    data_sh <= '0;
                    cnt     <= '0;
                    state   <= S_OP;
                end
                S_OP: begin
                    op <= {op[0], bit_in};
                    if (cnt == LAST_OP) begin
                        cnt   <= '0;
                        state <= op_is_legal(ext, {op[0], bit_in}) ? S_PORT : S_HUNT;
                    end else cnt <= cnt + 1'b1;
                end
                S_PORT: begin
                    port_sh <= {port_sh[PORT_W-2:0], bit_in};
                    if (cnt == LAST_PORT) begin
                        cnt   <= '0;
                        state <= S_ADDR;
                    end else cnt <= cnt + 1'b1;
                end
                S_ADDR: begin
                    addr_sh <= {addr_sh[FIELD_W-2:0], bit_in};
                    if (cnt == LAST_FLD) begin
                        cnt     <= '0;
                        state   <= S_TA;
                        active  <= (port_sh == port_id);
                        reading <= op_is_read(ext, op);
                        if (port_sh == port_id && op_is_read(ext, op)) begin
                            txn_valid <= 1'b1;
                            rd_start  <= 1'b1;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                S_TA: begin
                    if (cnt == LAST_TA) begin
                        cnt   <= '0;
                        state <= S_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                S_DATA: begin
                    data_sh <= {data_sh[DATA_W-2:0], bit_in};
                    if (cnt == LAST_DAT) begin
                        cnt   <= '0;
                        state <= S_HUNT;
                        if (active && !reading) txn_valid <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= S_HUNT;
            endcase
        end
    end

    assign hunt = (state == S_HUNT);
    assign txn  = '{ext: ext, op: op, addr: addr_sh, data: data_sh};

    assert_start_after_preamble_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_ST2) |-> $past(pre_ok));
    assert_legal_short_op_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_PORT && !ext) |-> (op == 2'b10 || op == 2'b01));
    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> !txn_valid);
    assert_read_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> (txn_valid && op_is_read(ext, op) && state == S_TA));
endmodule

// File: rtl/mdio_read_tx.sv
module mdio_read_tx
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            left    <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (rd_start) begin
            shreg   <= rd_data;
            left    <= CW'(DATA_W);
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b1;
        end else if (mdio_oe) begin
            if (left == '0) begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
            end else begin
                mdio_o <= shreg[DATA_W-1];
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                left   <= left - 1'b1;
            end
        end
    end

    assert_oe_from_read_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> $past(rd_start));
    assert_ta_low_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o);
    assert_oe_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && left == '0 && !rd_start) |=> !mdio_oe);
    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> !mdio_o);
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
    parameter int PRE_MIN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mdio_i,
    input  logic [4:0]  port_id,
    input  logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        txn_valid,
    output logic        txn_ext,
    output logic [1:0]  txn_op,
    output logic [4:0]  txn_addr,
    output logic [15:0] txn_wdata
);
    import mdio_pkg::*;

    logic      hunt;
    logic      pre_ok;
    logic      rd_start;
    mgmt_txn_t txn;

    mdio_preamble #(.PRE_MIN(PRE_MIN)) u_pre (
        .clk(clk), .rst(rst), .hunt(hunt), .bit_in(mdio_i), .pre_ok(pre_ok)
    );

    mdio_frame_rx u_rx (
        .clk(clk), .rst(rst), .bit_in(mdio_i), .pre_ok(pre_ok), .port_id(port_id),
        .hunt(hunt), .txn_valid(txn_valid), .rd_start(rd_start), .txn(txn)
    );

    mdio_read_tx u_tx (
        .clk(clk), .rst(rst), .rd_start(rd_start), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    assign txn_ext   = txn.ext;
    assign txn_op    = txn.op;
    assign txn_addr  = txn.addr;
    assign txn_wdata = txn.data;

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> (!txn_valid && !mdio_oe && !mdio_o));
endmodule

// File: tb/test_mdio_slave.sv
`timescale 1ns/1ps
module test_mdio_slave;
    localparam logic [4:0] STRAP = 5'b10110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdio_drv = 1'b1;
    logic        mdio_line;
    logic [15:0] rd_data = '0;
    logic        mdio_o, mdio_oe, txn_valid, txn_ext;
    logic [1:0]  txn_op;
    logic [4:0]  txn_addr;
    logic [15:0] txn_wdata;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    int n_strobe, n_oe, n_loud, bitno, s_bit, oe_bit;
    logic [16:0] rx_word;
    logic [23:0] s_fields;

    always #2 clk = ~clk;
    assign mdio_line = mdio_oe ? mdio_o : mdio_drv;

    mdio_slave i_mdio_slave (
        .clk(clk), .rst(rst), .mdio_i(mdio_line), .port_id(STRAP), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .txn_valid(txn_valid), .txn_ext(txn_ext),
        .txn_op(txn_op), .txn_addr(txn_addr), .txn_wdata(txn_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        if (txn_valid) begin
            n_strobe++;
            s_bit = bitno;
            s_fields = {txn_ext, txn_op, txn_addr, txn_wdata};
        end
        if (mdio_oe) begin
            if (n_oe == 0) oe_bit = bitno;
            n_oe++;
            rx_word = {rx_word[15:0], mdio_o};
        end else if (mdio_o) n_loud++;
        bitno++;
        mdio_drv = b;
    endtask

    task automatic run_frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] port, input logic [4:0] addr,
                             input logic [15:0] wd, input logic [15:0] rv, input string tag);
        bit match, legal, rd, hit;
        int a_idx, l_idx, exp_n;
        match = (port == STRAP);
        legal = (st == 2'b00) || (op == 2'b10) || (op == 2'b01);
        rd    = (st == 2'b00) ? op[1] : (op == 2'b10);
        hit   = match && legal && (npre >= 32);
        n_strobe = 0; n_oe = 0; n_loud = 0; bitno = 0; s_bit = -1; oe_bit = -1;
        rx_word = '0; s_fields = '0; rd_data = rv;
        drive_bit(1'b0);
        repeat (npre) drive_bit(1'b1);
        for (int i = 1; i >= 0; i--) drive_bit(st[i]);
        for (int i = 1; i >= 0; i--) drive_bit(op[i]);
        for (int i = 4; i >= 0; i--) drive_bit(port[i]);
        for (int i = 4; i >= 0; i--) drive_bit(addr[i]);
        if (rd) begin
            drive_bit(1'b1); drive_bit(1'b1);
            repeat (16) drive_bit(1'b1);
        end else begin
            drive_bit(1'b1); drive_bit(1'b0);
            for (int i = 15; i >= 0; i--) drive_bit(wd[i]);
        end
        repeat (4) drive_bit(1'b1);
        a_idx = npre + 15;
        l_idx = a_idx + 18;
        exp_n = hit ? 1 : 0;
        chk(n_strobe == exp_n, tag, n_strobe, exp_n);
        if (hit) begin
            chk(s_fields == {st == 2'b00, op, addr, rd ? 16'h0 : wd},
                (st == 2'b00) ? "R3 fields" : "R2 fields", 32'(s_fields),
                32'({st == 2'b00, op, addr, rd ? 16'h0 : wd}));
            if (rd) chk(s_bit == a_idx, "R7 strobe slot", s_bit, a_idx);
            else    chk(s_bit == l_idx, "R6 strobe slot", s_bit, l_idx);
        end
        chk(n_oe == ((hit && rd) ? 17 : 0), "R8 oe length", n_oe, (hit && rd) ? 17 : 0);
        if (hit && rd) begin
            chk(rx_word == {1'b0, rv}, "R8 read word", 32'(rx_word), 32'({1'b0, rv}));
            chk(oe_bit == a_idx + 1, "R7 capture slot", oe_bit, a_idx + 1);
        end
        chk(n_loud == 0, "R9 quiet line", n_loud, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!txn_valid && !mdio_oe && !mdio_o, "R11 in reset", {txn_valid, mdio_oe, mdio_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!txn_valid && !mdio_oe && !mdio_o, "R11 after reset", {txn_valid, mdio_oe, mdio_o}, 0);

        // R1: preamble boundary
        run_frame(31, 2'b01, 2'b01, STRAP, 5'd3, 16'h1234, 16'h0, "R1 short preamble");
        run_frame(31, 2'b01, 2'b10, STRAP, 5'd3, 16'h0, 16'hBEEF, "R1 short preamble rd");
        run_frame(32, 2'b01, 2'b01, STRAP, 5'd3, 16'h1234, 16'h0, "R1 exact preamble");
        run_frame(40, 2'b00, 2'b11, STRAP, 5'd9, 16'h0, 16'h8001, "R1 long preamble");

        // R5: sweep every port address, read and write
        for (int p = 0; p < 32; p++) begin
            run_frame(32, 2'b01, 2'b10, 5'(p), 5'(31 - p), 16'h0,
                      16'(p * 16'h0915 + 16'h7),
                      (5'(p) == STRAP) ? "R2 read match" : "R5 read other port");
            run_frame(32, 2'b01, 2'b01, 5'(p), 5'(p), 16'(16'hA5C3 ^ (p * 16'h0101)), 16'hFFFF,
                      (5'(p) == STRAP) ? "R2 write match" : "R5 write other port");
        end

        // R2/R4: every short opcode, each followed by a clean frame
        for (int o = 0; o < 4; o++) begin
            run_frame(32, 2'b01, 2'(o), STRAP, 5'd17, 16'h5A5A, 16'hC3C3,
                      (o == 0 || o == 3) ? "R4 short abort" : "R2 short op");
            run_frame(32, 2'b01, 2'b01, STRAP, 5'd2, 16'h0F0F, 16'h0, "R4 recovery");
        end

        // R3: every extended opcode over a few device numbers and words
        for (int o = 0; o < 4; o++) begin
            for (int d = 0; d < 32; d += 7) begin
                run_frame(32, 2'b00, 2'(o), STRAP, 5'(d), 16'(16'hFFFF - d * 16'h1111),
                          16'(d * 16'h2468 + 16'(o)), "R3 ext op");
            end
            run_frame(32, 2'b00, 2'(o), 5'(STRAP ^ 5'b00001), 5'd1, 16'h0001, 16'hAAAA,
                      "R5 ext other port");
        end

        // R10: back-to-back frames each give one strobe
        run_frame(32, 2'b00, 2'b00, STRAP, 5'd31, 16'hFFFF, 16'h0, "R10 back to back 1");
        run_frame(32, 2'b00, 2'b10, STRAP, 5'd31, 16'h0, 16'h0000, "R10 back to back 2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule